// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This combinational block sits between instruction fetch and the register file of a small 64-bit processor with a 16-bit word memory. It receives the current program counter and five consecutive memory words starting at that counter. It splits the first word into its fields. For opcodes that take an immediate, it joins the other four words into a 64-bit immediate. It also works out where the following instruction starts.

The block also selects the register file ports for the instruction. It drives two source indices and two destination indices: one destination for the ALU result and one for the memory result. Index 15 means no register. Stack instructions may name any register as the stack pointer, so the source and destination roles of the two register fields change with the opcode. Register fields that an opcode does not use are replaced with the null index before any of these choices is made.

Top module: `insn_decoder`

## Requirements
- R1: `instr_i[79:64]` is the first word. Its bits 15-12 appear on `opcode_o` and its bits 11-8 appear on `func_o`, both unchanged for every opcode.
- R2: The first word's bits 7-4 (field A) and bits 3-0 (field B) appear on `ra_o`/`rb_o` as follows. For opcodes 2, 4, 5, 6, 0xA and 0xB both fields pass unchanged. For opcodes 3, 8 and 9, `ra_o` is 0xF and `rb_o` passes. For every other opcode both outputs are 0xF.
- R3: For opcodes 3, 4, 5, 7 and 8, `imm_o` equals `instr_i[63:0]` (word two most significant, word five least). For every other opcode `imm_o` is all ones.
- R4: `next_pc_o` is `pc_i`+1 for opcodes 1, 2, 6, 9, 0xA and 0xB. It is `pc_i`+5 for opcodes 3, 4, 5, 7 and 8. It equals `pc_i` for opcode 0 and for opcodes 0xC-0xF.
- R5: The next-address sum is 24 bits wide and wraps modulo 2^24.
- R6: `src_a_o` is the forced field A for opcodes 2, 4, 6, 8 and 0xA, the forced field B for opcodes 9 and 0xB, and 0xF otherwise. For opcode 8 this always gives 0xF.
- R7: `src_b_o` is the forced field B for opcodes 2 and 4 through 0xB, and 0xF otherwise. For opcode 7 this gives 0xF.
- R8: `dst_alu_o` is the forced field B for opcodes 2, 3, 6, 8, 9, 0xA and 0xB, and 0xF otherwise.
- R9: `dst_mem_o` is the forced field A for opcodes 5 and 0xB, and 0xF otherwise.
- R10: `halt_o` is high only for opcode 0. `illegal_o` is high only for opcodes 0xC-0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 24 | Address of the first instruction word |
| instr_i | input | 80 | Five words starting at pc_i, first word in the top 16 bits |
| opcode_o | output | 4 | Opcode field |
| func_o | output | 4 | Function / condition field |
| ra_o | output | 4 | Field A after forcing |
| rb_o | output | 4 | Field B after forcing |
| imm_o | output | 64 | Assembled immediate, or all ones |
| next_pc_o | output | 24 | Address of the following instruction |
| src_a_o | output | 4 | Register file read index A |
| src_b_o | output | 4 | Register file read index B |
| dst_alu_o | output | 4 | Write index for the ALU result |
| dst_mem_o | output | 4 | Write index for the memory result |
| halt_o | output | 1 | Opcode 0 decoded |
| illegal_o | output | 1 | Opcode 0xC-0xF decoded |

## Verification
The cases that are hardest to see at the ports are those where forcing a field changes a source choice that looks as if it passes through. In the call opcode, field A names a real register, yet source A must come out null. In the jump opcode, source B must be null even though field B is not. The stimulus therefore puts non-null values in both register fields for every one of the sixteen opcodes, so that any forcing or role swap that is missing shows up as a wrong index. The address wrap is reached by placing one-word, five-word and zero-length instructions in the last words of the 24-bit address space.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int unsigned OP_W = 4;
  localparam int unsigned FLD_W = 4;
  localparam logic [FLD_W-1:0] NULL_IDX = '1;

  localparam logic [OP_W-1:0] OP_HALT  = 4'h0;
  localparam logic [OP_W-1:0] OP_NOP   = 4'h1;
  localparam logic [OP_W-1:0] OP_MOVC  = 4'h2;
  localparam logic [OP_W-1:0] OP_MOVI  = 4'h3;
  localparam logic [OP_W-1:0] OP_STORE = 4'h4;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'h5;
  localparam logic [OP_W-1:0] OP_ALU   = 4'h6;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'h7;
  localparam logic [OP_W-1:0] OP_CALL  = 4'h8;
  localparam logic [OP_W-1:0] OP_RET   = 4'h9;
  localparam logic [OP_W-1:0] OP_PUSH  = 4'hA;
  localparam logic [OP_W-1:0] OP_POP   = 4'hB;

  typedef enum logic [1:0] {
    LEN_ZERO = 2'd0,
    LEN_ONE  = 2'd1,
    LEN_FULL = 2'd2
  } len_e;

  function automatic len_e op_len(input logic [OP_W-1:0] op);
    case (op)
      OP_NOP, OP_MOVC, OP_ALU, OP_RET, OP_PUSH, OP_POP:   return LEN_ONE;
      OP_MOVI, OP_STORE, OP_LOAD, OP_JUMP, OP_CALL:      return LEN_FULL;
      default:                                           return LEN_ZERO;
    endcase
  endfunction

  function automatic logic keeps_a(input logic [OP_W-1:0] op);
    case (op)
      OP_MOVC, OP_STORE, OP_LOAD, OP_ALU, OP_PUSH, OP_POP: return 1'b1;
      default:                                             return 1'b0;
    endcase
  endfunction

  function automatic logic keeps_b(input logic [OP_W-1:0] op);
    case (op)
      OP_MOVI, OP_CALL, OP_RET: return 1'b1;
      default:                  return keeps_a(op);
    endcase
  endfunction
endpackage

// File: rtl/insn_fields.sv
module insn_fields
  import insn_dec_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [OP_W-1:0]   opcode_o,
  output logic [FLD_W-1:0]  func_o,
  output logic [FLD_W-1:0]  ra_o,
  output logic [FLD_W-1:0]  rb_o,
  output logic              halt_o,
  output logic              illegal_o
);
  localparam int unsigned OP_LSB = WORD_W - OP_W;
  localparam int unsigned FN_LSB = OP_LSB - FLD_W;
  localparam int unsigned RA_LSB = FN_LSB - FLD_W;

  logic [FLD_W-1:0] raw_a, raw_b;

  assign opcode_o = word_i[OP_LSB +: OP_W];
  assign func_o   = word_i[FN_LSB +: FLD_W];
  assign raw_a    = word_i[RA_LSB +: FLD_W];
  assign raw_b    = word_i[0 +: FLD_W];

  always_comb begin
    ra_o = keeps_a(opcode_o) ? raw_a : NULL_IDX;
    rb_o = keeps_b(opcode_o) ? raw_b : NULL_IDX;
  end

  assign halt_o    = (opcode_o == OP_HALT);
  assign illegal_o = (opcode_o > OP_POP);

  always_comb begin
    if (ra_o != NULL_IDX) a_r2_a_implies_b: assert (keeps_b(opcode_o));
    if (halt_o) a_r10_flags_excl: assert (!illegal_o);
  end
endmodule

// File: rtl/insn_imm.sv
module insn_imm
  import insn_dec_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned IMM_WORDS = 4,
  localparam int unsigned IMM_W    = WORD_W * IMM_WORDS
) (
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [IMM_W-1:0] words_i,
  output logic [IMM_W-1:0] imm_o
);
  logic use_imm;
  assign use_imm = (op_len(opcode_i) == LEN_FULL);

  for (genvar w = 0; w < IMM_WORDS; w++) begin : g_word
    // word 0 of words_i (most significant) is the second instruction word
    localparam int unsigned LSB = WORD_W * (IMM_WORDS - 1 - w);
    assign imm_o[LSB +: WORD_W] = use_imm ? words_i[LSB +: WORD_W] : '1;
  end
endmodule

// File: rtl/insn_next_addr.sv
module insn_next_addr
  import insn_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned IMM_WORDS = 4
) (
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam logic [ADDR_W-1:0] FULL_LEN = ADDR_W'(IMM_WORDS + 1);

  logic [ADDR_W-1:0] step;

  always_comb begin
    case (op_len(opcode_i))
      LEN_ONE:  step = ADDR_W'(1);
      LEN_FULL: step = FULL_LEN;
      default:  step = '0;
    endcase
  end

  assign next_pc_o = pc_i + step;
endmodule

// File: rtl/insn_reg_select.sv
module insn_reg_select
  import insn_dec_pkg::*;
(
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [FLD_W-1:0] ra_i,
  input  logic [FLD_W-1:0] rb_i,
  output logic [FLD_W-1:0] src_a_o,
  output logic [FLD_W-1:0] src_b_o,
  output logic [FLD_W-1:0] dst_alu_o,
  output logic [FLD_W-1:0] dst_mem_o
);
  always_comb begin
    case (opcode_i)
      OP_MOVC, OP_STORE, OP_ALU, OP_CALL, OP_PUSH: src_a_o = ra_i;
      OP_RET, OP_POP:                              src_a_o = rb_i;
      default:                                     src_a_o = NULL_IDX;
    endcase

    case (opcode_i)
      OP_MOVC, OP_STORE, OP_LOAD, OP_ALU, OP_JUMP,
      OP_CALL, OP_RET, OP_PUSH, OP_POP:            src_b_o = rb_i;
      default:                                     src_b_o = NULL_IDX;
    endcase

    case (opcode_i)
      OP_MOVC, OP_MOVI, OP_ALU, OP_CALL,
      OP_RET, OP_PUSH, OP_POP:                     dst_alu_o = rb_i;
      default:                                     dst_alu_o = NULL_IDX;
    endcase

    case (opcode_i)
      OP_LOAD, OP_POP: dst_mem_o = ra_i;
      default:         dst_mem_o = NULL_IDX;
    endcase
  end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned IMM_WORDS = 4,
  localparam int unsigned IMM_W    = WORD_W * IMM_WORDS,
  localparam int unsigned INSTR_W  = WORD_W * (IMM_WORDS + 1)
) (
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [OP_W-1:0]    opcode_o,
  output logic [FLD_W-1:0]   func_o,
  output logic [FLD_W-1:0]   ra_o,
  output logic [FLD_W-1:0]   rb_o,
  output logic [IMM_W-1:0]   imm_o,
  output logic [ADDR_W-1:0]  next_pc_o,
  output logic [FLD_W-1:0]   src_a_o,
  output logic [FLD_W-1:0]   src_b_o,
  output logic [FLD_W-1:0]   dst_alu_o,
  output logic [FLD_W-1:0]   dst_mem_o,
  output logic               halt_o,
  output logic               illegal_o
);
  localparam logic [ADDR_W-1:0] FULL_LEN = ADDR_W'(IMM_WORDS + 1);

  insn_fields #(.WORD_W(WORD_W)) u_fields (
    .word_i    (instr_i[INSTR_W-1 -: WORD_W]),
    .opcode_o  (opcode_o),
    .func_o    (func_o),
    .ra_o      (ra_o),
    .rb_o      (rb_o),
    .halt_o    (halt_o),
    .illegal_o (illegal_o)
  );

  insn_imm #(.WORD_W(WORD_W), .IMM_WORDS(IMM_WORDS)) u_imm (
    .opcode_i (opcode_o),
    .words_i  (instr_i[IMM_W-1:0]),
    .imm_o    (imm_o)
  );

  insn_next_addr #(.ADDR_W(ADDR_W), .IMM_WORDS(IMM_WORDS)) u_next (
    .opcode_i  (opcode_o),
    .pc_i      (pc_i),
    .next_pc_o (next_pc_o)
  );

  insn_reg_select u_regsel (
    .opcode_i  (opcode_o),
    .ra_i      (ra_o),
    .rb_i      (rb_o),
    .src_a_o   (src_a_o),
    .src_b_o   (src_b_o),
    .dst_alu_o (dst_alu_o),
    .dst_mem_o (dst_mem_o)
  );

  always_comb begin
    if (halt_o || illegal_o) a_r4_stay_put: assert (next_pc_o == pc_i);
    if ((next_pc_o - pc_i) != FULL_LEN) a_r3_imm_default: assert (imm_o == '1);
    if (src_a_o != NULL_IDX) a_r6_src_a_field: assert (src_a_o == ra_o || src_a_o == rb_o);
    if (dst_alu_o != NULL_IDX) a_r8_dst_alu_b: assert (dst_alu_o == rb_o);
    if (dst_mem_o != NULL_IDX) a_r9_dst_mem_a: assert (dst_mem_o == ra_o);
  end
endmodule

// File: tb/tb_insn_decoder.sv
`timescale 1ns/1ps
module tb_insn_decoder;
  logic        clk = 1'b0;
  logic [23:0] pc;
  logic [79:0] instr;
  logic [3:0]  opcode, func, ra, rb, src_a, src_b, dst_alu, dst_mem;
  logic [63:0] imm;
  logic [23:0] next_pc;
  logic        halt, illegal;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  insn_decoder dut (
    .pc_i(pc), .instr_i(instr), .opcode_o(opcode), .func_o(func),
    .ra_o(ra), .rb_o(rb), .imm_o(imm), .next_pc_o(next_pc),
    .src_a_o(src_a), .src_b_o(src_b), .dst_alu_o(dst_alu), .dst_mem_o(dst_mem),
    .halt_o(halt), .illegal_o(illegal)
  );

  // {opcode, func, field A, field B, pc}
  localparam logic [39:0] VEC [16] = '{
    40'h0_3_5_7_000100, 40'h1_9_2_4_000200, 40'h2_3_6_1_001000, 40'h3_0_8_9_00ABCD,
    40'h4_2_3_A_123456, 40'h5_1_C_4_7FFFF0, 40'h6_5_2_E_000010, 40'h7_4_6_B_400000,
    40'h8_0_5_4_0F1A90, 40'h9_0_3_6_000333, 40'hA_0_7_4_55AA55, 40'hB_0_1_5_AAAAAA,
    40'hC_7_1_2_000777, 40'hD_8_3_4_010101, 40'hE_F_5_6_FFFF00, 40'hF_F_7_8_00F000
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] e_a(input logic [3:0] op, input logic [3:0] a);
    return (op inside {4'h2, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB}) ? a : 4'hF;
  endfunction
  function automatic logic [3:0] e_b(input logic [3:0] op, input logic [3:0] b);
    return (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9, 4'hA, 4'hB}) ? b : 4'hF;
  endfunction
  function automatic logic [23:0] e_len(input logic [3:0] op);
    if (op inside {4'h1, 4'h2, 4'h6, 4'h9, 4'hA, 4'hB}) return 24'd1;
    if (op inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8}) return 24'd5;
    return 24'd0;
  endfunction

  task automatic apply(input logic [23:0] p, input logic [3:0] op, input logic [3:0] fn,
                       input logic [3:0] a, input logic [3:0] b, input logic [63:0] iw);
    @(negedge clk);
    pc = p;
    instr = {op, fn, a, b, iw};
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input logic [23:0] p, input logic [3:0] op, input logic [3:0] fn,
                           input logic [3:0] a, input logic [3:0] b, input logic [63:0] iw);
    logic [3:0] fa, fb, ea, eb, ead, eam;
    logic [63:0] ei;
    fa = e_a(op, a);
    fb = e_b(op, b);
    ea = (op inside {4'h2, 4'h4, 4'h6, 4'h8, 4'hA}) ? fa : (op inside {4'h9, 4'hB}) ? fb : 4'hF;
    eb = (op inside {4'h2, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB}) ? fb : 4'hF;
    ead = (op inside {4'h2, 4'h3, 4'h6, 4'h8, 4'h9, 4'hA, 4'hB}) ? fb : 4'hF;
    eam = (op inside {4'h5, 4'hB}) ? fa : 4'hF;
    ei = (op inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8}) ? iw : '1;
    chk({opcode, func} == {op, fn}, "R1 op/func", {56'd0, opcode, func}, {56'd0, op, fn});
    chk({ra, rb} == {fa, fb}, "R2 ra/rb", {56'd0, ra, rb}, {56'd0, fa, fb});
    chk(imm == ei, "R3 imm", imm, ei);
    chk(next_pc == p + e_len(op), "R4/R5 next_pc", {40'd0, next_pc}, {40'd0, p + e_len(op)});
    chk(src_a == ea, "R6 src_a", {60'd0, src_a}, {60'd0, ea});
    chk(src_b == eb, "R7 src_b", {60'd0, src_b}, {60'd0, eb});
    chk(dst_alu == ead, "R8 dst_alu", {60'd0, dst_alu}, {60'd0, ead});
    chk(dst_mem == eam, "R9 dst_mem", {60'd0, dst_mem}, {60'd0, eam});
    chk({halt, illegal} == {op == 4'h0, op >= 4'hC}, "R10 flags",
        {62'd0, halt, illegal}, {62'd0, op == 4'h0, op >= 4'hC});
  endtask

  task automatic run(input logic [23:0] p, input logic [3:0] op, input logic [3:0] fn,
                     input logic [3:0] a, input logic [3:0] b, input logic [63:0] iw);
    apply(p, op, fn, a, b, iw);
    check_all(p, op, fn, a, b, iw);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pc = '0;
    instr = '0;
    // idle state: all-zero input decodes as halt in place (R10, R4)
    @(posedge clk); #1;
    chk(halt && !illegal && next_pc == 24'd0, "R10 idle halt", {63'd0, halt}, 64'd1);
    chk(imm == '1, "R3 idle imm", imm, '1);

    for (int i = 0; i < 16; i++) begin
      run(VEC[i][23:0], VEC[i][39:36], VEC[i][35:32], VEC[i][31:28], VEC[i][27:24],
          {16'h1111 * (i + 1), 16'hBEEF, 16'h0F0F ^ 16'(i), 16'hC0DE});
    end

    // R5 wrap at top of address space
    run(24'hFFFFFE, 4'h3, 4'h0, 4'h1, 4'h2, 64'h0123_4567_89AB_CDEF);
    chk(next_pc == 24'h000003, "R5 wrap five", {40'd0, next_pc}, 64'h3);
    run(24'hFFFFFF, 4'h1, 4'h0, 4'h0, 4'h0, 64'h0);
    chk(next_pc == 24'h000000, "R5 wrap one", {40'd0, next_pc}, 64'h0);
    run(24'hFFFFFF, 4'h0, 4'h0, 4'h0, 4'h0, 64'h0);
    chk(next_pc == 24'hFFFFFF, "R4 halt at top", {40'd0, next_pc}, 64'hFFFFFF);
    // R6: call drops field A from source A even though it is non-null
    run(24'h000040, 4'h8, 4'h0, 4'h5, 4'h7, 64'h0000_0000_0000_0100);
    chk(src_a == 4'hF && dst_alu == 4'h7, "R6 call src_a null", {60'd0, src_a}, 64'hF);
    // R7: jump keeps no register for source B
    run(24'h000050, 4'h7, 4'h3, 4'h2, 4'h9, 64'h0);
    chk(src_b == 4'hF && imm == 64'h0, "R7 jump src_b null", {60'd0, src_b}, 64'hF);
    // R9: pop fills both destinations from swapped fields
    run(24'h000060, 4'hB, 4'h0, 4'h3, 4'h4, '1);
    chk(dst_mem == 4'h3 && dst_alu == 4'h4 && src_a == 4'h4, "R9 pop roles",
        {52'd0, dst_mem, dst_alu, src_a}, 64'h344);
    // R3: all-zero immediate words stay zero for load
    run(24'h000070, 4'h5, 4'h0, 4'h2, 4'h3, 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule